// File: doc/BRIEF.md
# Selective Encoding Scan-Slice Decompressor

This block expands a narrow stream of codewords into full-width scan slices for a wrapped core. One codeword arrives per clock on a bus whose width is the index field width plus two control bits. The index field is `$clog2(NUM_CHAINS+1)` bits wide. The block rebuilds one `NUM_CHAINS`-bit slice in an internal buffer. It hands the finished slice to the scan-chain inputs together with a single-cycle shift strobe.

A slice can be built in two ways. In the first, the slice is preset to a default fill value (all zeros or all ones) and single indexed bits are set to the opposite value. In the second, groups of adjacent bits are copied as literals: a group codeword gives the position of the group's first bit, and the codeword after it carries the bits themselves. The two methods may be mixed within one slice. A finished slice leaves the block when the next slice starts or when a flush request arrives.

Top module: `sed_decomp`

## Requirements
- R1: The codeword is `IDX_W+2` bits wide, where `IDX_W = $clog2(NUM_CHAINS+1)`. Bits `[IDX_W+1:IDX_W]` hold the control code and bits `[IDX_W-1:0]` hold the index or data field. Slice bit `i` drives scan chain `i`, with positions counted from 0.
- R2: Control code 00 opens a new slice preset to all zeros, and code 01 opens a new slice preset to all ones. The field of either code names a first target bit, which is set to the complement of the fill. The all-ones field value means no target.
- R3: Control code 10 sets the indexed bit of the open slice to the complement of that slice's fill value. The all-ones field value changes nothing.
- R4: Control code 11 names the first bit position of a group. In the next valid codeword, field bit `j` is written to slice bit `start+j`, for `j` from 0 to `IDX_W-1`.
- R5: The codeword that follows a code 11 word is always taken as group data, whatever its control bits hold. It never opens a slice and never causes a strobe.
- R6: When a start code (00 or 01) arrives while a slice is open, the slice built so far appears on `scan_slice` one clock later, and `scan_shift` is high for that one cycle. The first start after reset or after a flush produces no strobe.
- R7: A `flush` pulse while `cw_valid` is low releases the open slice with a strobe, in the same way as R6, and leaves no slice open. A flush with no slice open produces no strobe.
- R8: In codes 00, 01, 10 or 11, an index greater than or equal to `NUM_CHAINS` that is not the all-ones value changes no slice bit and sets `err_flag`. `err_flag` stays set until reset.
- R9: Group bits that would land at a position greater than `NUM_CHAINS-1` are dropped, and no error is raised for them.
- R10: A synchronous reset clears `scan_slice`, `scan_shift`, `err_flag`, the open-slice state and the pending-group state.
- R11: `scan_slice` holds its value in every cycle in which `scan_shift` is low.
- R12: A code 10 or code 11 codeword that arrives while no slice is open changes nothing and sets `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cw_valid | input | 1 | A codeword is present on `cw` this cycle |
| cw | input | IDX_W+2 | Codeword: control code in the top two bits, index or data field below them |
| flush | input | 1 | Release the open slice; acted on only while `cw_valid` is low |
| scan_slice | output | NUM_CHAINS | Last released slice, one bit per scan chain |
| scan_shift | output | 1 | One-cycle strobe marking a newly released slice |
| err_flag | output | 1 | Sticky flag for out-of-range indices and misplaced codes |

## Verification
The bound checker watches four things on every cycle:
- a strobe never appears without a codeword or flush in the cycle before;
- the slice output is stable between strobes;
- a data word that follows a group code never causes a strobe;
- the error flag is sticky, and every out-of-range target index sets it.

The values inside the rebuilt slices can only be shown by the bench scenarios. Each scenario is encoded by an independent model of the encoder and compared slice by slice. These scenarios cover:
- fill polarity;
- mixing group copies with single targets;
- truncation of a group at the top of the slice;
- the absence of a strobe for the first start, and for a flush with no slice open.

// File: rtl/sed_pkg.sv
package sed_pkg;

    // Two-bit control code carried in the top bits of every codeword
    typedef enum logic [1:0] {
        CW_START_ZERO = 2'b00,
        CW_START_ONE  = 2'b01,
        CW_TARGET     = 2'b10,
        CW_GROUP      = 2'b11
    } cw_ctrl_e;

    localparam int CTRL_W = 2;

endpackage

// File: rtl/sed_target_dec.sv
// Decodes an index field into a one-hot position mask and classifies the index.
module sed_target_dec #(
    parameter int NUM_CHAINS = 8,
    parameter int IDX_W      = $clog2(NUM_CHAINS + 1)
) (
    input  logic [IDX_W-1:0]      idx,
    output logic [NUM_CHAINS-1:0] onehot,
    output logic                  is_none,
    output logic                  is_bad
);
    localparam logic [IDX_W-1:0] NONE_IDX = {IDX_W{1'b1}};

    for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_pos
        assign onehot[i] = (idx == IDX_W'(i));
    end

    assign is_none = (idx == NONE_IDX);
    assign is_bad  = (int'(idx) >= NUM_CHAINS) && !is_none;

endmodule

// File: rtl/sed_group_place.sv
// Places an IDX_W-bit literal group at a start position; positions past the top are dropped.
module sed_group_place #(
    parameter int NUM_CHAINS = 8,
    parameter int IDX_W      = $clog2(NUM_CHAINS + 1)
) (
    input  logic [IDX_W-1:0]      start,
    input  logic [IDX_W-1:0]      data,
    output logic [NUM_CHAINS-1:0] mask,
    output logic [NUM_CHAINS-1:0] bits
);
    for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_pos
        always_comb begin
            mask[i] = 1'b0;
            bits[i] = 1'b0;
            for (int j = 0; j < IDX_W; j++) begin
                if (int'(start) + j == i) begin
                    mask[i] = 1'b1;
                    bits[i] = data[j];
                end
            end
        end
    end

endmodule

// File: rtl/sed_decomp.sv
module sed_decomp #(
    parameter int NUM_CHAINS = 8,
    parameter int IDX_W      = $clog2(NUM_CHAINS + 1),
    parameter int IN_W       = IDX_W + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cw_valid,
    input  logic [IN_W-1:0]       cw,
    input  logic                  flush,
    output logic [NUM_CHAINS-1:0] scan_slice,
    output logic                  scan_shift,
    output logic                  err_flag
);
    import sed_pkg::*;

    typedef struct packed {
        logic [NUM_CHAINS-1:0] sbuf;
        logic [NUM_CHAINS-1:0] slice;
        logic                  shift;
        logic                  fill;
        logic                  open;
        logic                  grp_pend;
        logic                  grp_ok;
        logic [IDX_W-1:0]      grp_start;
        logic                  err;
    } state_t;

    state_t state_d, state_q;

    cw_ctrl_e              ctrl;
    logic [IDX_W-1:0]      field;
    logic [NUM_CHAINS-1:0] tgt_oh;
    logic                  tgt_none;
    logic                  tgt_bad;
    logic [NUM_CHAINS-1:0] grp_mask;
    logic [NUM_CHAINS-1:0] grp_bits;

    // Internal state exposed to the bound checker
    logic grp_pend_w;
    logic slice_open_w;

    assign ctrl  = cw_ctrl_e'(cw[IN_W-1 -: CTRL_W]);
    assign field = cw[IDX_W-1:0];

    sed_target_dec #(.NUM_CHAINS(NUM_CHAINS), .IDX_W(IDX_W)) u_tdec (
        .idx     (field),
        .onehot  (tgt_oh),
        .is_none (tgt_none),
        .is_bad  (tgt_bad)
    );

    sed_group_place #(.NUM_CHAINS(NUM_CHAINS), .IDX_W(IDX_W)) u_gplace (
        .start (state_q.grp_start),
        .data  (field),
        .mask  (grp_mask),
        .bits  (grp_bits)
    );

    always_comb begin
        state_d       = state_q;
        state_d.shift = 1'b0;
        if (cw_valid) begin
            if (state_q.grp_pend) begin
                // Literal data word: control bits are not interpreted
                state_d.grp_pend = 1'b0;
                if (state_q.grp_ok) begin
                    state_d.sbuf = (state_q.sbuf & ~grp_mask) | (grp_bits & grp_mask);
                end
            end else begin
                unique case (ctrl)
                    CW_START_ZERO, CW_START_ONE: begin
                        if (state_q.open) begin
                            state_d.slice = state_q.sbuf;
                            state_d.shift = 1'b1;
                        end
                        state_d.open = 1'b1;
                        state_d.fill = ctrl[0];
                        state_d.sbuf = {NUM_CHAINS{ctrl[0]}};
                        if (tgt_bad) begin
                            state_d.err = 1'b1;
                        end else if (!tgt_none) begin
                            state_d.sbuf = ctrl[0] ? ~tgt_oh : tgt_oh;
                        end
                    end
                    CW_TARGET: begin
                        if (!state_q.open || tgt_bad) begin
                            state_d.err = 1'b1;
                        end else if (!tgt_none) begin
                            state_d.sbuf = state_q.fill ? (state_q.sbuf & ~tgt_oh)
                                                        : (state_q.sbuf | tgt_oh);
                        end
                    end
                    CW_GROUP: begin
                        state_d.grp_pend  = 1'b1;
                        state_d.grp_start = field;
                        state_d.grp_ok    = state_q.open && !tgt_bad && !tgt_none;
                        if (!state_q.open || tgt_bad) begin
                            state_d.err = 1'b1;
                        end
                    end
                    default: begin
                        state_d.err = state_q.err;
                    end
                endcase
            end
        end else if (flush) begin
            state_d.grp_pend = 1'b0;
            if (state_q.open) begin
                state_d.slice = state_q.sbuf;
                state_d.shift = 1'b1;
                state_d.open  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign scan_slice   = state_q.slice;
    assign scan_shift   = state_q.shift;
    assign err_flag     = state_q.err;
    assign grp_pend_w   = state_q.grp_pend;
    assign slice_open_w = state_q.open;

endmodule

// File: rtl/sed_decomp_chk.sv
module sed_decomp_chk #(
    parameter int NUM_CHAINS = 8,
    parameter int IDX_W      = $clog2(NUM_CHAINS + 1),
    parameter int IN_W       = IDX_W + 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cw_valid,
    input logic [IN_W-1:0]       cw,
    input logic                  flush,
    input logic [NUM_CHAINS-1:0] scan_slice,
    input logic                  scan_shift,
    input logic                  err_flag,
    input logic                  grp_pend,
    input logic                  slice_open
);
    localparam logic [IDX_W-1:0] NONE_IDX = {IDX_W{1'b1}};

    logic armed_q;
    logic rst_seen_q;
    logic bad_idx;
    logic tgt_word;

    assign bad_idx  = (int'(cw[IDX_W-1:0]) >= NUM_CHAINS) && (cw[IDX_W-1:0] != NONE_IDX);
    assign tgt_word = cw_valid && !grp_pend && slice_open && (cw[IN_W-1 -: 2] == 2'b10);

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q === 1'b1) begin
            a_reset_clear_r10: assert (!scan_shift && scan_slice == '0 && !err_flag && !grp_pend && !slice_open)
                else $error("reset state not clear");
        end
    end

    p_strobe_cause_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        scan_shift |-> ($past(cw_valid) || $past(flush)));

    p_slice_hold_r11: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !scan_shift |-> $stable(scan_slice));

    p_data_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (grp_pend && cw_valid) |=> !scan_shift);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    p_bad_index_r8: assert property (@(posedge clk) disable iff (rst)
        (tgt_word && bad_idx) |=> err_flag);

endmodule

bind sed_decomp sed_decomp_chk #(.NUM_CHAINS(NUM_CHAINS), .IDX_W(IDX_W), .IN_W(IN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cw_valid   (cw_valid),
    .cw         (cw),
    .flush      (flush),
    .scan_slice (scan_slice),
    .scan_shift (scan_shift),
    .err_flag   (err_flag),
    .grp_pend   (grp_pend_w),
    .slice_open (slice_open_w)
);

// File: tb/sim_sed_decomp.sv
module sim_sed_decomp;
    localparam int CLK_PERIOD = 10;
    localparam int M          = 8;
    localparam int IDX_W      = $clog2(M + 1);
    localparam int IN_W       = IDX_W + 2;
    localparam int NONE_IDX   = (1 << IDX_W) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cw_valid = 1'b0;
    logic [IN_W-1:0] cw = '0;
    logic            flush = 1'b0;
    logic [M-1:0]    scan_slice;
    logic            scan_shift;
    logic            err_flag;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int pushes = 0;
    bit done = 1'b0;

    logic [M-1:0] exp_q[$];
    string        tag_q[$];
    logic         open_b = 1'b0;
    logic [M-1:0] cur_exp = '0;
    string        cur_tag = "";

    always #(CLK_PERIOD / 2) clk = ~clk;

    sed_decomp #(.NUM_CHAINS(M)) u0 (
        .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw(cw), .flush(flush),
        .scan_slice(scan_slice), .scan_shift(scan_shift), .err_flag(err_flag)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard on each strobe
    always @(negedge clk) begin
        if (!rst && scan_shift) begin
            strobes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected strobe", int'(scan_slice), 0);
            end else begin
                logic [M-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(scan_slice == e, t, int'(scan_slice), int'(e));
            end
        end
    end

    task automatic send(input logic [1:0] c, input int f);
        cw_valid = 1'b1;
        cw = {c, f[IDX_W-1:0]};
        @(negedge clk);
        cw_valid = 1'b0;
        cw = '0;
    endtask

    task automatic close_slice();
        if (open_b) begin
            exp_q.push_back(cur_exp);
            tag_q.push_back(cur_tag);
            pushes++;
        end
    endtask

    // Reference encoder: single-bit targets against a fill (R2, R3)
    task automatic enc_single(input logic [M-1:0] want, input logic fill, input string tag);
        int first;
        first = NONE_IDX;
        for (int i = 0; i < M; i++) if (want[i] != fill && first == NONE_IDX) first = i;
        close_slice();
        send({1'b0, fill}, first);
        for (int i = first + 1; i < M; i++) if (want[i] != fill) send(2'b10, i);
        open_b = 1'b1;
        cur_exp = want;
        cur_tag = tag;
    endtask

    // Reference encoder: group copies; data words carry control bits 00 (R4, R5)
    task automatic enc_group(input logic [M-1:0] want, input string tag);
        close_slice();
        send(2'b00, NONE_IDX);
        for (int g = 0; g < M; g += IDX_W) begin
            int d;
            d = 0;
            for (int j = 0; j < IDX_W; j++) if (g + j < M && want[g + j]) d |= (1 << j);
            send(2'b11, g);
            send(2'b00, d);
        end
        open_b = 1'b1;
        cur_exp = want;
        cur_tag = tag;
    endtask

    task automatic do_flush();
        close_slice();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        open_b = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        open_b = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(scan_slice == '0, "R10 slice after reset", int'(scan_slice), 0);
        check(!scan_shift, "R10 strobe after reset", int'(scan_shift), 0);
        check(!err_flag, "R10 error after reset", int'(err_flag), 0);
    endtask

    initial begin
        int s0;
        @(negedge clk);
        do_reset();

        // R12: target code with no open slice
        send(2'b10, 3);
        @(negedge clk);
        check(err_flag, "R12 error on orphan target", int'(err_flag), 1);
        check(strobes == 0, "R12 no strobe", strobes, 0);
        do_reset();

        // R2 / R6: first start gives no strobe
        enc_single(8'b0000_1000, 1'b0, "R2 fill0 index3");
        @(negedge clk);
        check(strobes == 0, "R6 first start no strobe", strobes, 0);
        enc_single(8'b1110_1111, 1'b1, "R3 fill1 cleared bit");
        enc_single(8'b1010_0101, 1'b0, "R3 several targets");
        enc_single(8'h00, 1'b0, "R2 no target fill0");
        enc_single(8'hFF, 1'b1, "R2 no target fill1");

        // R4 / R5: group copies with data words carrying control 00
        enc_group(8'b1100_0011, "R4 group copy");
        enc_group(8'h5A, "R5 data word not a start");

        // R4: fill one, then a zero group at position 2
        close_slice();
        send(2'b01, NONE_IDX);
        send(2'b11, 2);
        send(2'b00, 0);
        open_b = 1'b1; cur_exp = 8'b1100_0011; cur_tag = "R4 mixed fill and group";

        // R9: group at 6 truncated past bit 7
        close_slice();
        send(2'b00, NONE_IDX);
        send(2'b11, 6);
        send(2'b00, 4'b1111);
        open_b = 1'b1; cur_exp = 8'b1100_0000; cur_tag = "R9 truncated group";
        check(!err_flag, "R9 no error on truncation", int'(err_flag), 0);

        // R8: out-of-range target ignored, error set
        close_slice();
        send(2'b00, 2);
        send(2'b10, 9);
        open_b = 1'b1; cur_exp = 8'b0000_0100; cur_tag = "R8 bad index ignored";
        check(err_flag, "R8 error raised", int'(err_flag), 1);

        // R7: flush releases the last slice
        s0 = strobes;
        do_flush();
        @(negedge clk);
        check(strobes == s0 + 1, "R7 flush strobe", strobes, s0 + 1);
        check(!scan_shift, "R6 strobe one cycle", int'(scan_shift), 0);
        repeat (3) @(negedge clk);
        check(scan_slice == 8'b0000_0100, "R11 slice held", int'(scan_slice), 8'h04);
        check(err_flag, "R8 error sticky", int'(err_flag), 1);

        // R7: flush with nothing open
        s0 = strobes;
        do_flush();
        repeat (2) @(negedge clk);
        check(strobes == s0, "R7 empty flush no strobe", strobes, s0);

        // R1: codeword layout, start fill1 with target at the top index
        enc_single(8'b0111_1111, 1'b1, "R1 top index position");
        do_flush();
        repeat (2) @(negedge clk);

        check(exp_q.size() == 0, "R6 all slices delivered", exp_q.size(), 0);
        check(strobes == pushes, "R6 strobe count", strobes, pushes);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule